// File: doc/BRIEF.md
# Prioritized Interrupt Identifier Unit

This unit keeps one sticky pending flag for each of a set of message objects (32 by default) and one more for a status event. Each cycle it names the single most urgent pending source as a 16-bit identifier code. The status source always ranks first. Among message objects, the lowest object number wins, however the flags were ordered in time.

A pending flag is set by a one-cycle pulse. It stays set until software removes it. A message-object flag is removed through a per-object clear request. The status flag is removed as a side effect of reading the status register, which appears here as a read strobe.

The interrupt line toward the processor is raised whenever the identifier is nonzero and the enable bit is set. The pending flags are also readable as two 16-bit words.

Top module: `irq_id_unit`

## Requirements
- R1: After synchronous reset, all pending flags and the enable bit are zero, so `int_id_o` is 0x0000, both pending words are zero and `irq_o` is low.
- R2: When message object k (1..NUM_OBJ, driven on bit k-1 of `obj_set_i`) is the only pending source, `int_id_o` equals k.
- R3: While the status flag is pending, `int_id_o` is 0x8000 whatever message objects are also pending.
- R4: With several message objects pending and no status, `int_id_o` names the lowest-numbered pending object, regardless of the order in which they were set.
- R5: A pending flag stays set in every cycle in which it receives no clear (no `obj_clr_i` bit for an object, no `stat_rd_i` for status).
- R6: A pulse on bit k-1 of `obj_clr_i` clears object k only, and `int_id_o` moves to the next-ranked pending source one cycle after the clear request.
- R7: A pulse on `stat_rd_i` clears the status flag one cycle later and leaves every message-object flag unchanged.
- R8: When a set and a clear reach the same source in the same cycle, the flag is set afterwards. This holds both for an object's set and clear bits and for `stat_evt_i` together with `stat_rd_i`.
- R9: `irq_o` is high exactly when `int_id_o` is nonzero and the enable bit is set. The enable bit is loaded from `ien_wd_i` in the cycle after `ien_we_i` is high.
- R10: `pend_lo_o` bit k-1 shows object k for k = 1..16, and `pend_hi_o` bit k-17 shows object k for k = 17..32.
- R11: `int_id_o` is only ever 0x0000, 0x8000, or a value from 1 to NUM_OBJ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| obj_set_i | input | NUM_OBJ | Per-object pending set pulses, bit k-1 = object k |
| obj_clr_i | input | NUM_OBJ | Per-object pending clear requests, bit k-1 = object k |
| stat_evt_i | input | 1 | Status event pulse, sets the status flag |
| stat_rd_i | input | 1 | Status register read strobe, clears the status flag |
| ien_we_i | input | 1 | Write strobe for the interrupt enable bit |
| ien_wd_i | input | 1 | New value of the interrupt enable bit |
| int_id_o | output | ID_W | Identifier of the highest-priority pending source |
| pend_lo_o | output | WORD_W | Pending flags of objects 1..16 |
| pend_hi_o | output | WORD_W | Pending flags of objects 17..32 |
| irq_o | output | 1 | Interrupt line to the processor |

## Verification
The bench builds the unit with its default parameters: 32 objects, a 16-bit identifier and 16-bit pending words. At this size the priority scan covers its full width, object 32 is reachable as the lowest rank, and both halves of the pending readout carry live bits. Sparse random set and clear masks, together with random status events, reads and enable writes, make the identifier walk through many mixes of pending sources. Directed steps cover the extreme object numbers and the same-cycle set-and-clear collisions.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;
  localparam int unsigned DEF_NUM_OBJ = 32;
  localparam int unsigned DEF_ID_W    = 16;
  localparam int unsigned DEF_WORD_W  = 16;

  // Code that names the status source: the top bit of the identifier.
  function automatic logic [DEF_ID_W-1:0] status_code();
    return {1'b1, {(DEF_ID_W-1){1'b0}}};
  endfunction
endpackage

// File: rtl/irq_sticky_cell.sv
// One sticky pending flag. A set pulse beats a clear in the same cycle.
module irq_sticky_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)        flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R5
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/irq_pend_bank.sv
// Array of sticky flags, one per message object.
module irq_pend_bank #(
  parameter int unsigned NUM_OBJ = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] set_i,
  input  logic [NUM_OBJ-1:0] clr_i,
  output logic [NUM_OBJ-1:0] pend_o
);
  for (genvar g = 0; g < NUM_OBJ; g++) begin : g_cell
    irq_sticky_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_i[g]),
      .clr_i  (clr_i[g]),
      .flag_o (pend_o[g])
    );
    // R6: a clear without a set empties the flag
    clr_only_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
  end
endmodule

// File: rtl/irq_prio_enc.sv
// Scans pending flags and builds the identifier code.
module irq_prio_enc #(
  parameter int unsigned NUM_OBJ = 32,
  parameter int unsigned ID_W    = 16
) (
  input  logic [NUM_OBJ-1:0] pend_i,
  input  logic               stat_i,
  output logic [ID_W-1:0]    id_o
);
  localparam logic [ID_W-1:0] STAT_CODE = {1'b1, {(ID_W-1){1'b0}}};

  logic [ID_W-1:0] obj_code;

  // The loop runs downward, so the lowest pending index is the last one written.
  always_comb begin
    obj_code = '0;
    for (int i = NUM_OBJ - 1; i >= 0; i--) begin
      if (pend_i[i]) obj_code = ID_W'(i + 1);
    end
  end

  assign id_o = stat_i ? STAT_CODE : obj_code;
endmodule

// File: rtl/irq_id_unit.sv
module irq_id_unit #(
  parameter int unsigned NUM_OBJ = irq_id_pkg::DEF_NUM_OBJ,
  parameter int unsigned ID_W    = irq_id_pkg::DEF_ID_W,
  parameter int unsigned WORD_W  = irq_id_pkg::DEF_WORD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_OBJ-1:0] obj_set_i,
  input  logic [NUM_OBJ-1:0] obj_clr_i,
  input  logic               stat_evt_i,
  input  logic               stat_rd_i,
  input  logic               ien_we_i,
  input  logic               ien_wd_i,
  output logic [ID_W-1:0]    int_id_o,
  output logic [WORD_W-1:0]  pend_lo_o,
  output logic [WORD_W-1:0]  pend_hi_o,
  output logic               irq_o
);
  localparam int unsigned     PAD_W     = 2 * WORD_W;
  localparam logic [ID_W-1:0] STAT_CODE = {1'b1, {(ID_W-1){1'b0}}};
  localparam logic [ID_W-1:0] MAX_OBJ   = ID_W'(NUM_OBJ);

  logic [NUM_OBJ-1:0] pend;
  logic               stat_pend;
  logic               ien_q;
  logic [PAD_W-1:0]   pend_pad;

  irq_pend_bank #(.NUM_OBJ(NUM_OBJ)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .set_i  (obj_set_i),
    .clr_i  (obj_clr_i),
    .pend_o (pend)
  );

  irq_sticky_cell u_stat (
    .clk    (clk),
    .rst    (rst),
    .set_i  (stat_evt_i),
    .clr_i  (stat_rd_i),
    .flag_o (stat_pend)
  );

  irq_prio_enc #(.NUM_OBJ(NUM_OBJ), .ID_W(ID_W)) u_enc (
    .pend_i (pend),
    .stat_i (stat_pend),
    .id_o   (int_id_o)
  );

  always_ff @(posedge clk) begin
    if (rst)           ien_q <= 1'b0;
    else if (ien_we_i) ien_q <= ien_wd_i;
  end

  assign irq_o = ien_q && (int_id_o != '0);

  // Pending readout: object k lands on bit k-1 of the padded vector.
  always_comb begin
    pend_pad = '0;
    pend_pad[NUM_OBJ-1:0] = pend;
  end
  assign pend_lo_o = pend_pad[WORD_W-1:0];
  assign pend_hi_o = pend_pad[PAD_W-1:WORD_W];

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $fell(rst) |-> (int_id_o == '0 && !irq_o));
  // R11
  legal_code_chk: assert property (@(posedge clk) disable iff (rst)
    (int_id_o == '0) || (int_id_o == STAT_CODE) || (int_id_o <= MAX_OBJ));
  // R3
  status_first_chk: assert property (@(posedge clk) disable iff (rst)
    stat_pend |-> (int_id_o == STAT_CODE));
  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat_pend && int_id_o != '0) |->
      (pend[int_id_o - 1'b1] &&
       ((pend & ((NUM_OBJ'(1) << (int_id_o - 1'b1)) - NUM_OBJ'(1))) == '0)));
  // R7
  read_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd_i && !stat_evt_i) |=> !stat_pend);
  // R9
  line_follows_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ien_we_i |=> (irq_o == ($past(ien_wd_i) && int_id_o != '0)));
endmodule

// File: tb/irq_id_unit_tb.sv
`timescale 1ns/100ps
module irq_id_unit_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  obj_set = '0;
  logic [N-1:0]  obj_clr = '0;
  logic          stat_evt = 1'b0;
  logic          stat_rd = 1'b0;
  logic          ien_we = 1'b0;
  logic          ien_wd = 1'b0;
  logic [15:0]   int_id;
  logic [15:0]   pend_lo;
  logic [15:0]   pend_hi;
  logic          irq;

  int checks = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [N-1:0] m_pend = '0;
  logic         m_stat = 1'b0;
  logic         m_ien = 1'b0;

  always #2.5 clk = ~clk;

  irq_id_unit dut_i (
    .clk(clk), .rst(rst), .obj_set_i(obj_set), .obj_clr_i(obj_clr),
    .stat_evt_i(stat_evt), .stat_rd_i(stat_rd), .ien_we_i(ien_we),
    .ien_wd_i(ien_wd), .int_id_o(int_id), .pend_lo_o(pend_lo),
    .pend_hi_o(pend_hi), .irq_o(irq)
  );

  function automatic logic [15:0] exp_id(logic [N-1:0] p, logic s);
    if (s) return 16'h8000;
    for (int i = 0; i < N; i++) if (p[i]) return 16'(i + 1);
    return 16'h0000;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [15:0] e;
    e = exp_id(m_pend, m_stat);
    chk(tag, "id", 32'(int_id), 32'(e));
    chk("R10", "pend", {pend_hi, pend_lo}, m_pend);
    chk("R9", "irq", 32'(irq), 32'(m_ien && (e != 0)));
  endtask

  // Drive at a falling edge, update the model, check at the next falling edge.
  task automatic step(string tag, logic [N-1:0] s, logic [N-1:0] c,
                      logic se, logic sr, logic we, logic wd);
    obj_set = s; obj_clr = c; stat_evt = se; stat_rd = sr; ien_we = we; ien_wd = wd;
    m_pend = s | (m_pend & ~c);
    m_stat = se | (m_stat & ~sr);
    if (we) m_ien = wd;
    @(negedge clk);
    obj_set = '0; obj_clr = '0; stat_evt = 0; stat_rd = 0; ien_we = 0;
    check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", "id", 32'(int_id), 0);
    chk("R1", "pend", {pend_hi, pend_lo}, 0);
    chk("R1", "irq", 32'(irq), 0);
    // R9: enable on
    step("R9", '0, '0, 0, 0, 1, 1);
    // R2: extreme objects alone
    step("R2", 32'h8000_0000, '0, 0, 0, 0, 0);
    chk("R2", "obj32", 32'(int_id), 32);
    step("R6", '0, 32'h8000_0000, 0, 0, 0, 0);
    step("R2", 32'h0000_0001, '0, 0, 0, 0, 0);
    chk("R2", "obj1", 32'(int_id), 1);
    step("R6", '0, 32'h0000_0001, 0, 0, 0, 0);
    // R4: set later-ranked after earlier, order ignored
    step("R4", 32'h0001_0000, '0, 0, 0, 0, 0);
    step("R4", 32'h0000_0100, '0, 0, 0, 0, 0);
    chk("R4", "obj9", 32'(int_id), 9);
    // R5: hold without clear
    step("R5", '0, '0, 0, 0, 0, 0);
    // R3: status outranks
    step("R3", '0, '0, 1, 0, 0, 0);
    chk("R3", "stat", 32'(int_id), 32'h8000);
    // R8: status set and read together
    step("R8", '0, '0, 1, 1, 0, 0);
    chk("R8", "stat", 32'(int_id), 32'h8000);
    // R7: read clears only status
    step("R7", '0, '0, 0, 1, 0, 0);
    chk("R7", "after read", 32'(int_id), 9);
    // R6: clear moves to next
    step("R6", '0, 32'h0000_0100, 0, 0, 0, 0);
    chk("R6", "next", 32'(int_id), 17);
    // R8: object set and clear together
    step("R8", 32'h0001_0000, 32'h0001_0000, 0, 0, 0, 0);
    chk("R8", "obj17", 32'(int_id), 17);
    // R9: disable drops line
    step("R9", '0, '0, 0, 0, 1, 0);
    chk("R9", "off", 32'(irq), 0);
    step("R6", '0, 32'h0001_0000, 0, 0, 1, 1);
    chk("R11", "empty", 32'(int_id), 0);
    // Random mix
    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] s, c;
      s = $urandom & $urandom & $urandom & $urandom;
      c = $urandom & $urandom;
      step("R4", s, c, ($urandom % 9) == 0, ($urandom % 5) == 0,
           ($urandom % 13) == 0, 1'($urandom));
      if (int_id != 0 && int_id != 16'h8000 && int_id > N) begin
        chk("R11", "legal", 32'(int_id), 0);
      end
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule